// File: doc/BRIEF.md
# I2C Register-Buffer Target

This block is an I2C target with a fixed 7-bit address. It lets a bus controller read and write a small byte-addressed buffer. It watches SCL, drives SDA only as an open-drain pull-down, and follows the bus by detecting START, repeated START and STOP conditions on the synchronized lines.

In a write transfer, the first data byte after the address loads an internal location pointer. Each later byte is stored at the pointer, and the pointer then steps forward, wrapping after the last location. In a read transfer, the target sends the byte at the pointer and steps the pointer. The pointer keeps its value between transfers, so a write that only sets the pointer, followed by a repeated START and a read, returns data from the chosen location. Local logic has its own parallel port into the same buffer.

Top module: `i2c_regbuf_target`

## Requirements
- R1: The target acknowledges an address byte whose bits 7:1 equal `DEV_ADDR`; bit 0 of that byte selects read (1) or write (0). A byte with any other address is not acknowledged, and every later byte is neither acknowledged nor stored until the next START.
- R2: After a write address, the first data byte is taken as the pointer. It is acknowledged when its value is below `DEPTH`.
- R3: A pointer byte whose value is `DEPTH` or more is not acknowledged, and the pointer is set to 0.
- R4: Each write data byte after the pointer byte is acknowledged and stored at the pointer. The pointer then advances by one, going from `DEPTH-1` to 0.
- R5: In a read, the target sends the byte at the pointer, most significant bit first, and advances the pointer with the same wrap. It loads the next byte only after the controller acknowledges, so after N bytes are sent the pointer has moved by exactly N.
- R6: The pointer keeps its value across STOP and repeated START. A read therefore starts where the previous transfer left the pointer.
- R7: A read byte that the controller does not acknowledge ends the transmission. SDA stays released, so further clocked bits read as 1, until the next START.
- R8: A STOP at any point returns the target to idle with SDA released. A START that comes after two or more bits of a byte is treated as a bus error: the target returns to idle and does not answer the address that follows.
- R9: The target changes SDA only while SCL is low, and it samples SDA on the rising edge of SCL.
- R10: SCL and SDA pass through a two-flop synchronizer. A falling SDA while SCL is high is a START, and a rising SDA while SCL is high is a STOP.
- R11: The local port writes `loc_wdata` at `loc_addr` when `loc_we` is high. `loc_rdata` shows the byte at `loc_addr` one cycle later. All locations read 0 after reset.
- R12: When the local port and the bus write the same location in the same cycle, the local data is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| loc_we | input | 1 | Local write strobe |
| loc_addr | input | AW | Local location index |
| loc_wdata | input | 8 | Local write data |
| loc_rdata | output | 8 | Byte at loc_addr, one cycle late |

## Verification
The bench targets the pointer edge cases:
- Writes and reads that cross from the last location to location 0. A design with a wrong wrap writes past the buffer or reads the wrong byte.
- Pointer bytes exactly at and above the buffer size. A design that acknowledges these, or keeps the bad value, would point at a phantom location.
- Back-to-back reads that check the pointer moves only on acknowledged bytes. A design that prefetches too eagerly skips a location after a NACK.

It also checks the bus-event cases:
- A START in the middle of a byte, and a STOP in the middle of a byte. A design that treats these as a legal repeated START would wrongly acknowledge the next address or store data.
- An address that does not match. A careless design would store the later bytes.
- A local write that lands in the same cycle as a bus write. A design that gives priority to the wrong side would keep the bus data instead of the local data.

// File: rtl/i2c_regbuf_pkg.sv
package i2c_regbuf_pkg;

  typedef enum logic [3:0] {
    TS_IDLE,
    TS_ADDR,
    TS_ACKW,
    TS_ACKS,
    TS_WR,
    TS_RD,
    TS_RACK,
    TS_RSMP,
    TS_RLOAD,
    TS_SKIP
  } tgt_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe_q;
  logic [STAGES-1:0] sda_pipe_q;
  logic              scl_prev_q;
  logic              sda_prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe_q <= '1;
          sda_pipe_q <= '1;
        end else begin
          scl_pipe_q <= scl_i;
          sda_pipe_q <= sda_i;
        end
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe_q <= '1;
          sda_pipe_q <= '1;
        end else begin
          scl_pipe_q <= {scl_pipe_q[STAGES-2:0], scl_i};
          sda_pipe_q <= {sda_pipe_q[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_prev_q <= scl_lvl;
      sda_prev_q <= sda_lvl;
    end
  end

  assign scl_lvl   = scl_pipe_q[STAGES-1];
  assign sda_lvl   = sda_pipe_q[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_prev_q;
  assign scl_fall  = ~scl_lvl & scl_prev_q;
  assign start_det = scl_lvl & scl_prev_q & sda_prev_q & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev_q & ~sda_prev_q & sda_lvl;

endmodule

// File: rtl/regbuf_mem.sv
module regbuf_mem #(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          loc_we,
  input  logic [AW-1:0] loc_addr,
  input  logic [7:0]    loc_wdata,
  output logic [7:0]    loc_rdata,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata
);

  logic [7:0]       mem_q [DEPTH];
  logic [7:0]       rdata_q;
  logic [DEPTH-1:0] loc_hit;
  logic [DEPTH-1:0] bus_hit;

  // Per-location write decode; the local hit takes precedence below.
  for (genvar g = 0; g < DEPTH; g++) begin : g_dec
    assign loc_hit[g] = loc_we & (loc_addr == AW'(g));
    assign bus_hit[g] = bus_we & (bus_addr == AW'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (loc_hit[i])      mem_q[i] <= loc_wdata;
        else if (bus_hit[i]) mem_q[i] <= bus_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= mem_q[loc_addr];
  end

  assign loc_rdata = rdata_q;
  assign bus_rdata = mem_q[bus_addr];

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_regbuf_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2C,
  parameter int         DEPTH    = 32,
  parameter int         AW       = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [7:0]    bus_rdata,
  output logic          sda_oe,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  tgt_state_e    state_q, state_n;
  logic [2:0]    bitcnt_q, bitcnt_n;
  logic [7:0]    sh_q, sh_n;
  logic          ack_q, ack_n;
  logic          rd_q, rd_n;
  logic          ploaded_q, ploaded_n;
  logic [AW-1:0] ptr_q, ptr_n;

  logic [7:0]    rx_byte;
  logic [AW-1:0] ptr_inc;
  logic          byte_done;
  logic          in_byte;

  assign rx_byte   = {sh_q[6:0], sda_lvl};
  assign ptr_inc   = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  assign byte_done = scl_rise & (bitcnt_q == 3'd7);
  assign in_byte   = (state_q == TS_ADDR) | (state_q == TS_WR) | (state_q == TS_RD);

  always_comb begin
    state_n   = state_q;
    bitcnt_n  = bitcnt_q;
    sh_n      = sh_q;
    ack_n     = ack_q;
    rd_n      = rd_q;
    ploaded_n = ploaded_q;
    ptr_n     = ptr_q;
    bus_we    = 1'b0;
    if (stop_det) begin
      state_n  = TS_IDLE;
      bitcnt_n = '0;
    end else if (start_det) begin
      bitcnt_n = '0;
      // The first SCL rise of a repeated START counts as one bit.
      if (in_byte && bitcnt_q > 3'd1) state_n = TS_IDLE;
      else                            state_n = TS_ADDR;
    end else begin
      case (state_q)
        TS_ADDR: if (scl_rise) begin
          sh_n     = rx_byte;
          bitcnt_n = bitcnt_q + 3'd1;
          if (byte_done) begin
            if (rx_byte[7:1] == DEV_ADDR) begin
              state_n = TS_ACKW;
              ack_n   = 1'b1;
              rd_n    = rx_byte[0];
              if (rx_byte[0]) begin
                sh_n  = bus_rdata;
                ptr_n = ptr_inc;
              end else begin
                ploaded_n = 1'b0;
              end
            end else begin
              state_n = TS_SKIP;
            end
          end
        end
        TS_ACKW: if (scl_fall) state_n = TS_ACKS;
        TS_ACKS: if (scl_fall) begin
          bitcnt_n = '0;
          if (!ack_q)    state_n = TS_SKIP;
          else if (rd_q) state_n = TS_RD;
          else           state_n = TS_WR;
        end
        TS_WR: if (scl_rise) begin
          sh_n     = rx_byte;
          bitcnt_n = bitcnt_q + 3'd1;
          if (byte_done) begin
            state_n = TS_ACKW;
            ack_n   = 1'b1;
            if (!ploaded_q) begin
              ploaded_n = 1'b1;
              if (32'(rx_byte) >= DEPTH) begin
                ack_n = 1'b0;
                ptr_n = '0;
              end else begin
                ptr_n = rx_byte[AW-1:0];
              end
            end else begin
              bus_we = 1'b1;
              ptr_n  = ptr_inc;
            end
          end
        end
        TS_RD: begin
          if (scl_rise) begin
            bitcnt_n = bitcnt_q + 3'd1;
            if (bitcnt_q == 3'd7) state_n = TS_RACK;
          end else if (scl_fall) begin
            sh_n = {sh_q[6:0], 1'b0};
          end
        end
        TS_RACK: if (scl_fall) state_n = TS_RSMP;
        TS_RSMP: if (scl_rise) begin
          if (!sda_lvl) begin
            sh_n    = bus_rdata;
            ptr_n   = ptr_inc;
            state_n = TS_RLOAD;
          end else begin
            state_n = TS_SKIP;
          end
        end
        TS_RLOAD: if (scl_fall) begin
          bitcnt_n = '0;
          state_n  = TS_RD;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= TS_IDLE;
      bitcnt_q  <= '0;
      sh_q      <= '0;
      ack_q     <= 1'b0;
      rd_q      <= 1'b0;
      ploaded_q <= 1'b0;
      ptr_q     <= '0;
    end else begin
      state_q   <= state_n;
      bitcnt_q  <= bitcnt_n;
      sh_q      <= sh_n;
      ack_q     <= ack_n;
      rd_q      <= rd_n;
      ploaded_q <= ploaded_n;
      ptr_q     <= ptr_n;
    end
  end

  assign sda_oe    = ((state_q == TS_ACKS) & ack_q) |
                     (((state_q == TS_RD) | (state_q == TS_RACK)) & ~sh_q[7]);
  assign bus_addr  = ptr_q;
  assign bus_wdata = rx_byte;

endmodule

// File: rtl/i2c_regbuf_target.sv
module i2c_regbuf_target #(
  parameter logic [6:0] DEV_ADDR = 7'h2C,
  parameter int         DEPTH    = 32,
  parameter int         AW       = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic          loc_we,
  input  logic [AW-1:0] loc_addr,
  input  logic [7:0]    loc_wdata,
  output logic [7:0]    loc_rdata
);

  logic [1:0]    rsync_q;
  logic          rst_int_n;
  logic          scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic          bus_we;
  logic [AW-1:0] bus_addr;
  logic [7:0]    bus_wdata, bus_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  i2c_line_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  i2c_target_fsm #(.DEV_ADDR(DEV_ADDR), .DEPTH(DEPTH), .AW(AW)) u_fsm (
    .clk(clk), .rst_n(rst_int_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .bus_rdata(bus_rdata), .sda_oe(sda_oe), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata)
  );

  regbuf_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk(clk), .rst_n(rst_int_n), .loc_we(loc_we), .loc_addr(loc_addr),
    .loc_wdata(loc_wdata), .loc_rdata(loc_rdata), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

endmodule

// File: rtl/regbuf_chk.sv
module regbuf_chk #(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_lvl,
  input logic          scl_rise,
  input logic          scl_fall,
  input logic          start_det,
  input logic          stop_det,
  input logic          sda_oe,
  input logic          bus_we,
  input logic [AW-1:0] ptr
);

  assert_ptr_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && ptr == AW'(DEPTH - 1)) |=> (ptr == '0));

  assert_release_on_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  assert_sda_moves_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!scl_lvl || $past(stop_det) || $past(start_det)));

  assert_write_on_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> scl_rise);

  assert_bus_events_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_det, stop_det, scl_rise, scl_fall}));

endmodule

bind i2c_regbuf_target regbuf_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .scl_lvl(scl_lvl), .scl_rise(scl_rise),
  .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
  .sda_oe(sda_oe), .bus_we(bus_we), .ptr(bus_addr)
);

// File: tb/sim_i2c_regbuf_target.sv
`timescale 1ns/1ps
module sim_i2c_regbuf_target;

  localparam int DEPTH = 32;
  localparam int AW    = $clog2(DEPTH);
  localparam int Q     = 8;
  localparam logic [7:0] AW_BYTE = 8'h58;  // address 0x2C, write
  localparam logic [7:0] AR_BYTE = 8'h59;  // address 0x2C, read
  // pointer in [15:8], data in [7:0]
  localparam logic [15:0] VEC [0:5] = '{16'h03A5, 16'h045A, 16'h11C3,
                                        16'h1F7E, 16'h003C, 16'h0C96};

  logic clk, rst_n;
  logic scl_b, ctrl_low;
  logic sda_oe;
  logic loc_we;
  logic [AW-1:0] loc_addr;
  logic [7:0] loc_wdata, loc_rdata;
  logic sda_line;
  int n_chk, n_err, r9_viol;
  logic done, mon_on, oe_prev;

  assign sda_line = ~(ctrl_low | sda_oe);

  i2c_regbuf_target #(.DEV_ADDR(7'h2C), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_b), .sda_i(sda_line),
    .sda_oe(sda_oe), .loc_we(loc_we), .loc_addr(loc_addr),
    .loc_wdata(loc_wdata), .loc_rdata(loc_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (mon_on) begin
      if (sda_oe !== oe_prev && scl_b) r9_viol++;
    end
    oe_prev = sda_oe;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    ctrl_low = 1'b0; wq(Q);
    scl_b = 1'b1;    wq(Q);
    ctrl_low = 1'b1; wq(Q);
    scl_b = 1'b0;    wq(Q);
  endtask

  task automatic i2c_stop();
    ctrl_low = 1'b1; wq(Q);
    scl_b = 1'b1;    wq(Q);
    ctrl_low = 1'b0; wq(Q);
  endtask

  task automatic send_bits(input int n, input logic [7:0] pat);
    for (int i = 7; i > 7 - n; i--) begin
      ctrl_low = ~pat[i]; wq(Q);
      scl_b = 1'b1; wq(2 * Q);
      scl_b = 1'b0; wq(Q);
    end
  endtask

  task automatic send_byte_c(input logic [7:0] b, input logic col,
                             input logic [AW-1:0] ca, input logic [7:0] cd,
                             output logic ack);
    for (int i = 7; i >= 0; i--) begin
      ctrl_low = ~b[i]; wq(Q);
      scl_b = 1'b1;
      if (col && i == 0) begin
        wq(2);
        loc_we = 1'b1; loc_addr = ca; loc_wdata = cd;
        wq(1);
        loc_we = 1'b0;
        wq(2 * Q - 3);
      end else begin
        wq(2 * Q);
      end
      scl_b = 1'b0; wq(Q);
    end
    ctrl_low = 1'b0; wq(Q);
    scl_b = 1'b1;    wq(Q);
    ack = ~sda_line; wq(Q);
    scl_b = 1'b0;    wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_byte_c(b, 1'b0, '0, 8'h00, ack);
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] d);
    ctrl_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wq(Q);
      scl_b = 1'b1; wq(Q);
      d[i] = sda_line; wq(Q);
      scl_b = 1'b0; wq(Q);
    end
    ctrl_low = ack; wq(Q);
    scl_b = 1'b1;   wq(2 * Q);
    scl_b = 1'b0;   wq(Q);
    ctrl_low = 1'b0;
  endtask

  task automatic loc_write(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    loc_we = 1'b1; loc_addr = a; loc_wdata = d;
    @(negedge clk);
    loc_we = 1'b0;
  endtask

  task automatic loc_read(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk);
    loc_addr = a;
    @(negedge clk);
    d = loc_rdata;
  endtask

  initial begin
    logic ack;
    logic [7:0] d;
    n_chk = 0; n_err = 0; r9_viol = 0; done = 1'b0; mon_on = 1'b0;
    scl_b = 1'b1; ctrl_low = 1'b0;
    loc_we = 1'b0; loc_addr = '0; loc_wdata = '0;
    rst_n = 1'b0;
    wq(5);
    rst_n = 1'b1;
    wq(5);
    // Reset state (R11)
    chk("R11 reset sda_oe", {7'd0, sda_oe}, 8'h00);
    loc_read(5'd20, d);
    chk("R11 reset loc_rdata", d, 8'h00);
    mon_on = 1'b1;

    // Table: set pointer, write one byte, repeated START, read it back
    for (int v = 0; v < 6; v++) begin
      i2c_start();
      send_byte(AW_BYTE, ack);  chk("R1 R10 write address ack", {7'd0, ack}, 8'h01);
      send_byte(VEC[v][15:8], ack); chk("R2 pointer ack", {7'd0, ack}, 8'h01);
      send_byte(VEC[v][7:0], ack);  chk("R4 data ack", {7'd0, ack}, 8'h01);
      i2c_start();
      send_byte(AW_BYTE, ack);  chk("R6 rewrite address ack", {7'd0, ack}, 8'h01);
      send_byte(VEC[v][15:8], ack); chk("R2 pointer reload ack", {7'd0, ack}, 8'h01);
      i2c_start();
      send_byte(AR_BYTE, ack);  chk("R1 read address ack", {7'd0, ack}, 8'h01);
      recv_byte(1'b0, d);       chk("R5 R6 read after pointer set", d, VEC[v][7:0]);
      i2c_stop();
      loc_read(VEC[v][12:8], d); chk("R11 local read of bus write", d, VEC[v][7:0]);
    end

    // Write across the end of the buffer (R4)
    i2c_start();
    send_byte(AW_BYTE, ack);
    send_byte(8'h1E, ack);
    send_byte(8'hD1, ack); chk("R4 ack at 30", {7'd0, ack}, 8'h01);
    send_byte(8'hD2, ack); chk("R4 ack at 31", {7'd0, ack}, 8'h01);
    send_byte(8'hD3, ack); chk("R4 ack after wrap", {7'd0, ack}, 8'h01);
    i2c_stop();
    loc_read(5'd30, d); chk("R4 location 30", d, 8'hD1);
    loc_read(5'd31, d); chk("R4 location 31", d, 8'hD2);
    loc_read(5'd0,  d); chk("R4 wrapped to 0", d, 8'hD3);

    // Read across the end of the buffer (R5)
    i2c_start();
    send_byte(AW_BYTE, ack);
    send_byte(8'h1E, ack);
    i2c_start();
    send_byte(AR_BYTE, ack);
    recv_byte(1'b1, d); chk("R5 read 30", d, 8'hD1);
    recv_byte(1'b1, d); chk("R5 read 31", d, 8'hD2);
    recv_byte(1'b0, d); chk("R5 read wrapped 0", d, 8'hD3);
    i2c_stop();

    // Pointer kept across transfers, moved once per sent byte (R5, R6)
    loc_write(5'd1, 8'h4B);
    loc_write(5'd2, 8'h69);
    i2c_start();
    send_byte(AR_BYTE, ack);
    recv_byte(1'b0, d); chk("R6 read continues at 1", d, 8'h4B);
    i2c_stop();
    i2c_start();
    send_byte(AR_BYTE, ack);
    recv_byte(1'b0, d); chk("R5 no extra advance after NACK", d, 8'h69);
    // NACK ends transmission (R7)
    recv_byte(1'b1, d); chk("R7 released after NACK", d, 8'hFF);
    i2c_stop();

    // Out-of-range pointer (R3)
    i2c_start();
    send_byte(AW_BYTE, ack);
    send_byte(8'h28, ack); chk("R3 pointer 40 NACK", {7'd0, ack}, 8'h00);
    i2c_stop();
    i2c_start();
    send_byte(AR_BYTE, ack);
    recv_byte(1'b0, d); chk("R3 pointer forced to 0", d, 8'hD3);
    i2c_stop();
    i2c_start();
    send_byte(AW_BYTE, ack);
    send_byte(8'h20, ack); chk("R3 pointer equal to depth NACK", {7'd0, ack}, 8'h00);
    i2c_stop();

    // Address mismatch (R1)
    i2c_start();
    send_byte(8'h26, ack); chk("R1 foreign address NACK", {7'd0, ack}, 8'h00);
    send_byte(8'h05, ack); chk("R1 ignored byte NACK", {7'd0, ack}, 8'h00);
    send_byte(8'h77, ack); chk("R1 ignored data NACK", {7'd0, ack}, 8'h00);
    i2c_stop();
    loc_read(5'd5, d); chk("R1 nothing stored", d, 8'h00);
    i2c_start();
    send_byte(8'h27, ack); chk("R1 foreign read address NACK", {7'd0, ack}, 8'h00);
    i2c_stop();

    // START in the middle of a byte (R8)
    i2c_start();
    send_byte(AW_BYTE, ack);
    send_byte(8'h06, ack);
    send_bits(4, 8'hA0);
    i2c_start();
    chk("R8 SDA released after bus error", {7'd0, sda_oe}, 8'h00);
    send_byte(AW_BYTE, ack); chk("R8 idle after bus error", {7'd0, ack}, 8'h00);
    send_byte(8'h55, ack);
    i2c_stop();
    loc_read(5'd6, d); chk("R8 no write after bus error", d, 8'h00);
    i2c_start();
    send_byte(AW_BYTE, ack); chk("R8 recovery address ack", {7'd0, ack}, 8'h01);
    send_byte(8'h06, ack);
    send_byte(8'h24, ack);
    i2c_stop();
    loc_read(5'd6, d); chk("R8 recovery write", d, 8'h24);

    // STOP in the middle of a byte (R8)
    i2c_start();
    send_byte(AW_BYTE, ack);
    send_byte(8'h07, ack);
    send_bits(3, 8'hE0);
    i2c_stop();
    chk("R8 SDA released after STOP", {7'd0, sda_oe}, 8'h00);
    loc_read(5'd7, d); chk("R8 no write after STOP", d, 8'h00);

    // Same-cycle collision (R12)
    i2c_start();
    send_byte(AW_BYTE, ack);
    send_byte(8'h09, ack);
    send_byte_c(8'hAB, 1'b1, 5'd9, 8'h5D, ack);
    chk("R12 bus byte still acked", {7'd0, ack}, 8'h01);
    i2c_stop();
    loc_read(5'd9, d); chk("R12 local write wins", d, 8'h5D);

    // SDA moves only while SCL is low (R9)
    chk("R9 SDA changes with SCL high", r9_viol[7:0], 8'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule